// File: doc/BRIEF.md
# Byte-Stream Memory Debug Server

This block is a hardware command server that sits behind the byte channels of a serial port. A host can use it to read and write memory and to start code, with no processor running. Received bytes and transmitted bytes each pass through a valid/ready handshake. The server stays silent until the host sends an activation byte. After that it takes one-byte opcodes, each followed by 64-bit arguments sent least-significant byte first.

Read and write commands move a stream of bytes of any 64-bit length. Each stream is framed by an acknowledge byte at its start and an end-of-transmission byte at its end. Data moves through a simple word-wide memory port with a request/grant handshake. A read returns its data one cycle or more later, flagged by a valid signal. Unaligned start addresses and partial tail words are handled with byte strobes, so bytes outside the requested range are never changed.

The execute command passes a target address to a launch interface and waits there until completion is signalled. It then acknowledges a second time and returns an 8-byte result.

Top module: `byte_mem_server`

## Requirements
- R1: After reset the server is inactive. In that state it accepts every received byte and ignores it: nothing is transmitted and no memory or execute request is made. Only the byte 0x06 activates the server.
- R2: Opcode 0x11 (read) is followed by an 8-byte address and an 8-byte length, each least-significant byte first. The reply is 0x06, then the memory bytes from address, address+1, and so on up to length bytes, then 0x04.
- R3: Opcode 0x12 (write) takes the same two arguments. The reply is 0x06. The server then accepts length data bytes and stores them at consecutive addresses starting at the given address. It sends 0x04 only after the last memory write has been granted.
- R4: The memory port carries word-aligned addresses of DW/8 bytes per word. Byte k of a word is data bits [8k+7:8k]. A write drives a strobe bit only for bytes inside the requested range, so bytes outside that range in a shared word keep their values.
- R5: Opcode 0x13 (execute) is followed by an 8-byte address. The reply is 0x06. The server then holds the execute request with that address until the completion input pulses. After completion it sends a second 0x06, followed by the 8-byte result, least-significant byte first.
- R6: A read or write with a length of zero replies 0x06 and then 0x04 and makes no memory request.
- R7: An opcode other than 0x11, 0x12 or 0x13 is dropped without any reply, and the next byte is taken as a new opcode.
- R8: After a command completes, the server takes the next opcode at once, without a new activation byte.
- R9: While a request is stalled, the request and its payload stay stable. This holds for a transmit byte waiting for tx_ready, a memory request waiting for grant, and an execute request waiting for completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_data | input | 8 | Byte received from the host |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Server takes the received byte |
| tx_data | output | 8 | Byte sent to the host |
| tx_valid | output | 1 | Transmit byte present |
| tx_ready | input | 1 | Serial side takes the transmit byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Word-aligned byte address |
| mem_wdata | output | DW | Write data |
| mem_strb | output | DW/8 | Byte enables of a write |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| exec_req | output | 1 | Launch request, held until completion |
| exec_addr | output | 64 | Launch address |
| exec_done | input | 1 | Completion pulse |
| exec_retval | input | 64 | Result, sampled when exec_done is high |

## Verification
A wrong state or a corrupted counter shows up on the transmit port within a few bytes. It appears as a missing or extra 0x06/0x04 frame byte, a data byte from the wrong address, or a reply that arrives too early. A wrong byte offset or a wrong strobe shows up only in the memory contents, so the memory image is compared with a reference after every write command. Random stalls on grant, transmit and completion exercise the hold behaviour, where a lost request would hang the server or repeat a byte.

// File: rtl/byte_mem_server.sv
module byte_mem_server #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      rx_data,
  input  logic            rx_valid,
  output logic            rx_ready,
  output logic [7:0]      tx_data,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic            mem_req,
  output logic            mem_we,
  output logic [63:0]     mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW/8-1:0] mem_strb,
  input  logic            mem_gnt,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  output logic            exec_req,
  output logic [63:0]     exec_addr,
  input  logic            exec_done,
  input  logic [63:0]     exec_retval
);
  localparam int BPW  = DW / 8;
  localparam int OFFW = $clog2(BPW);
  localparam logic [7:0] B_ACK = 8'h06;
  localparam logic [7:0] B_EOT = 8'h04;
  localparam logic [7:0] C_RD  = 8'h11;
  localparam logic [7:0] C_WR  = 8'h12;
  localparam logic [7:0] C_EX  = 8'h13;

  typedef enum logic [3:0] {
    IDLE, OPC, ARG, ACK1, RD_REQ, RD_WAIT, RD_TX,
    WR_RX, WR_REQ, EX_RUN, ACK2, RET, EOT
  } st_t;

  st_t              st;
  logic [7:0]       op;
  logic [3:0]       cnt;
  logic [63:0]      addr, len, rv;
  logic [DW-1:0]    wbuf;
  logic [BPW-1:0]   strb;
  logic [63-OFFW:0] wword;

  wire [OFFW-1:0] off     = addr[OFFW-1:0];
  wire [63:0]     addr_n  = addr + 64'd1;
  wire            last    = (len == 64'd1);
  wire            wrap    = (addr_n[OFFW-1:0] == '0);
  wire            rx_fire = rx_valid && rx_ready;
  wire            tx_fire = tx_valid && tx_ready;

  assign rx_ready  = (st == IDLE) || (st == OPC) || (st == ARG) || (st == WR_RX);
  assign tx_valid  = (st == ACK1) || (st == RD_TX) || (st == ACK2) || (st == RET) || (st == EOT);
  assign mem_req   = (st == RD_REQ) || (st == WR_REQ);
  assign mem_we    = (st == WR_REQ);
  assign mem_addr  = {(st == WR_REQ) ? wword : addr[63:OFFW], {OFFW{1'b0}}};
  assign mem_wdata = wbuf;
  assign mem_strb  = mem_we ? strb : '0;
  assign exec_req  = (st == EX_RUN);
  assign exec_addr = addr;

  always_comb begin
    case (st)
      RD_TX:   tx_data = wbuf[{off, 3'b000} +: 8];
      RET:     tx_data = rv[{cnt[2:0], 3'b000} +: 8];
      EOT:     tx_data = B_EOT;
      default: tx_data = B_ACK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      op    <= '0;
      cnt   <= '0;
      addr  <= '0;
      len   <= '0;
      rv    <= '0;
      wbuf  <= '0;
      strb  <= '0;
      wword <= '0;
    end else begin
      case (st)
        IDLE: if (rx_fire && rx_data == B_ACK) st <= OPC;
        OPC: if (rx_fire) begin
          op  <= rx_data;
          cnt <= '0;
          if (rx_data == C_RD || rx_data == C_WR || rx_data == C_EX) st <= ARG;
        end
        ARG: if (rx_fire) begin
          if (!cnt[3]) addr[{cnt[2:0], 3'b000} +: 8] <= rx_data;
          else         len[{cnt[2:0], 3'b000} +: 8]  <= rx_data;
          cnt <= cnt + 4'd1;
          if (cnt == 4'd15 || (cnt == 4'd7 && op == C_EX)) st <= ACK1;
        end
        ACK1: if (tx_fire) begin
          strb <= '0;
          if (op == C_EX)          st <= EX_RUN;
          else if (len == 64'd0)   st <= EOT;
          else if (op == C_RD)     st <= RD_REQ;
          else                     st <= WR_RX;
        end
        RD_REQ: if (mem_gnt) st <= RD_WAIT;
        RD_WAIT: if (mem_rvalid) begin
          wbuf <= mem_rdata;
          st   <= RD_TX;
        end
        RD_TX: if (tx_fire) begin
          addr <= addr_n;
          len  <= len - 64'd1;
          if (last)      st <= EOT;
          else if (wrap) st <= RD_REQ;
        end
        WR_RX: if (rx_fire) begin
          wbuf[{off, 3'b000} +: 8] <= rx_data;
          strb[off] <= 1'b1;
          wword     <= addr[63:OFFW];
          addr      <= addr_n;
          len       <= len - 64'd1;
          if (last || wrap) st <= WR_REQ;
        end
        WR_REQ: if (mem_gnt) begin
          strb <= '0;
          st   <= (len == 64'd0) ? EOT : WR_RX;
        end
        EX_RUN: if (exec_done) begin
          rv  <= exec_retval;
          cnt <= '0;
          st  <= ACK2;
        end
        ACK2: if (tx_fire) st <= RET;
        RET: if (tx_fire) begin
          cnt <= cnt + 4'd1;
          if (cnt[2:0] == 3'd7) st <= OPC;
        end
        EOT: if (tx_fire) st <= OPC;
        default: st <= IDLE;
      endcase
    end
  end

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_strb));

  // R5
  exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_req && !exec_done |=> exec_req && $stable(exec_addr));

  // R4
  wr_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_strb != '0);

  // R1
  dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && (tx_valid || mem_req || exec_req)));
endmodule

// File: tb/test_byte_mem_server.sv
module test_byte_mem_server;
  localparam int CLK_P = 10;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic [7:0] rx_data = 0, tx_data;
  logic rx_valid = 0, rx_ready, tx_valid, tx_ready = 0;
  logic mem_req, mem_we, mem_gnt = 0, mem_rvalid = 0;
  logic [63:0] mem_addr, exec_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = 0;
  logic [DW/8-1:0] mem_strb;
  logic exec_req, exec_done = 0;
  logic [63:0] exec_retval = 0;

  always #(CLK_P/2) clk = ~clk;

  byte_mem_server #(.DW(DW)) i_byte_mem_server (
    .clk(clk), .rst_n(rst_n),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_strb(mem_strb), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .exec_req(exec_req), .exec_addr(exec_addr),
    .exec_done(exec_done), .exec_retval(exec_retval)
  );

  int n_chk = 0, n_bad = 0;
  int n_rd = 0, n_wr = 0;
  logic [7:0] mdl  [0:1023];
  logic [7:0] refm [0:1023];
  logic [63:0] ex_val, ex_seen;
  bit ex_fired = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog act=hung exp=finished");
    summary();
  end

  // memory responder
  initial begin
    logic [DW-1:0] rd_word;
    bit rd_pend;
    rd_pend = 0;
    rd_word = '0;
    forever begin
      @(negedge clk);
      mem_gnt = 0; mem_rvalid = 0;
      if (rd_pend) begin
        mem_rvalid = 1; mem_rdata = rd_word; rd_pend = 0;
      end else if (mem_req && ($urandom % 3 != 0)) begin
        mem_gnt = 1;
        for (int k = 0; k < DW/8; k++) begin
          if (mem_we && mem_strb[k]) mdl[mem_addr[9:0] + k] = mem_wdata[8*k +: 8];
          rd_word[8*k +: 8] = mdl[mem_addr[9:0] + k];
        end
        if (mem_we) n_wr++; else begin n_rd++; rd_pend = 1; end
      end
    end
  end

  // execute responder
  initial begin
    forever begin
      @(negedge clk);
      if (exec_req) begin
        repeat ($urandom_range(1, 5)) @(negedge clk);
        ex_seen = exec_addr;
        exec_retval = ex_val;
        exec_done = 1;
        ex_fired = 1;
        @(negedge clk);
        exec_done = 0;
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_data = b; rx_valid = 1;
    while (!rx_ready) @(negedge clk);
    @(posedge clk); #1 rx_valid = 0;
  endtask

  task automatic send64(input logic [63:0] v);
    for (int i = 0; i < 8; i++) send(v[8*i +: 8]);
  endtask

  task automatic recv(output logic [7:0] b, input bit stall);
    if (stall) repeat ($urandom_range(0, 3)) @(negedge clk);
    @(negedge clk);
    tx_ready = 1;
    while (!tx_valid) @(negedge clk);
    b = tx_data;
    @(posedge clk); #1 tx_ready = 0;
  endtask

  task automatic expect_byte(input logic [7:0] e, input string req);
    logic [7:0] b;
    recv(b, 1'b0);
    chk(b == e, req, b, e);
  endtask

  task automatic do_read(input logic [63:0] a, input logic [63:0] l, input bit stall, input string req);
    logic [7:0] b;
    int bad;
    bad = 0;
    send(8'h11); send64(a); send64(l);
    expect_byte(8'h06, req);
    for (int i = 0; i < int'(l); i++) begin
      recv(b, stall);
      if (b !== refm[a[9:0] + i]) begin
        if (bad == 0) chk(0, req, b, refm[a[9:0] + i]);
        bad++;
      end
    end
    if (bad == 0) chk(1, req, 0, 0);
    expect_byte(8'h04, req);
  endtask

  task automatic cmp_mem(input string req);
    int bad;
    bad = -1;
    for (int i = 0; i < 1024; i++) if (bad < 0 && mdl[i] !== refm[i]) bad = i;
    if (bad < 0) chk(1, req, 0, 0);
    else chk(0, req, mdl[bad], refm[bad]);
  endtask

  task automatic do_write(input logic [63:0] a, input logic [63:0] l, input string req);
    logic [7:0] d;
    send(8'h12); send64(a); send64(l);
    expect_byte(8'h06, req);
    for (int i = 0; i < int'(l); i++) begin
      d = 8'($urandom);
      refm[a[9:0] + i] = d;
      send(d);
    end
    expect_byte(8'h04, req);
    cmp_mem(req);
  endtask

  task automatic quiet(input string req);
    bit seen;
    seen = 0;
    repeat (6) begin
      @(negedge clk);
      if (tx_valid || mem_req || exec_req) seen = 1;
    end
    chk(!seen && rx_ready, req, {62'd0, seen, rx_ready}, 64'd1);
  endtask

  task automatic do_exec(input logic [63:0] a, input logic [63:0] v);
    logic [7:0] b;
    logic [63:0] got;
    ex_val = v; ex_fired = 0;
    send(8'h13); send64(a);
    expect_byte(8'h06, "R5 first ack");
    expect_byte(8'h06, "R5 second ack");
    chk(ex_fired, "R5 ack before completion", 0, 1);
    chk(ex_seen == a, "R5 launch address", ex_seen, a);
    for (int i = 0; i < 8; i++) begin
      recv(b, 1'b1);
      got[8*i +: 8] = b;
    end
    chk(got == v, "R5 result bytes", got, v);
  endtask

  initial begin
    int a, l;
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) begin
      mdl[i] = 8'($urandom);
      refm[i] = mdl[i];
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!tx_valid && !mem_req && !exec_req && rx_ready, "R1 reset state",
        {60'd0, tx_valid, mem_req, exec_req, rx_ready}, 64'd1);

    // R1: bytes before activation are ignored
    send(8'h11); send(8'h12); send(8'h13); send(8'h55);
    quiet("R1 ignored before activation");
    chk(n_rd == 0 && n_wr == 0, "R1 no memory before activation", n_rd + n_wr, 0);
    send(8'h06);

    // R6: zero length framing
    do_read(64'd100, 64'd0, 0, "R6 zero read");
    do_write(64'd200, 64'd0, "R6 zero write");
    chk(n_rd == 0 && n_wr == 0, "R6 no memory access", n_rd + n_wr, 0);

    // R2/R4 directed unaligned read and write
    do_read(64'd257, 64'd7, 0, "R2 R4 unaligned read");
    do_write(64'd301, 64'd2, "R4 inside one word");
    do_write(64'd403, 64'd9, "R3 R4 straddle write");
    do_read(64'd400, 64'd16, 1, "R9 stalled read");

    // R7: unknown opcode dropped, then R8 next command w/o reactivation
    send(8'h7F);
    quiet("R7 unknown opcode silent");
    do_read(64'd403, 64'd9, 0, "R7 R8 command after drop");

    do_exec(64'h8000_0000_1234_5678, 64'hFEDC_BA98_7654_3210);
    do_read(64'd0, 64'd5, 0, "R8 read after exec");

    // random mix
    for (int it = 0; it < 30; it++) begin
      a = $urandom_range(0, 960);
      l = $urandom_range(1, 40);
      if (it % 2 == 0) do_write(64'(a), 64'(l), "R3 random write");
      else do_read(64'(a), 64'(l), it % 3 == 0, "R2 random read");
    end
    do_exec(64'h40, 64'h1);
    summary();
  end
endmodule